// File: doc/BRIEF.md
# Programmable Local Interrupt Timer

This block is a countdown timer of the kind that sits beside the interrupt core of a processor. Software programs it through a 32-bit register port: a vector/control word, an initial count, a divide selector for the prescaler, and a current count that can only be read. After an initial count is written, the block counts down once per prescaled tick. When the count runs out it raises an interrupt request that carries its vector, either a single time or again on every period.

The request is held until the interrupt core accepts it with a one-cycle acknowledge. While the request is open, a delivery-status bit in the control word reads as one. A mask bit stops expiries from raising requests, but the count keeps running. The prescaler ratio comes from a 4-bit code. The codes do not rise in order, and one of them selects divide-by-1.

Top module: `lapic_timer`

## Requirements
- R1: After reset the control word at 0x320 reads 0x0001_0000 (mask set, vector 0, one-shot, no pending delivery). The initial count at 0x380, the current count at 0x390 and the divide code at 0x3E0 all read 0, and irq_req is low.
- R2: The divide code sits in bits 3:0 of 0x3E0 and reads back as written. It maps to the tick ratio as follows: 0x0 gives /2, 0x1 /4, 0x2 /8, 0x3 /16, 0x8 /32, 0x9 /64, 0xA /128 and 0xB /1. Bit 2 has no effect on the ratio, so 0x4 gives /2. A write to the divide code or to the initial count restarts the prescaler, and the first tick comes that many cycles after the write.
- R3: A write to 0x380 loads the value into the current count and starts counting. Writing zero stops the timer and leaves the current count at zero.
- R4: The current count drops by one on each tick. In one-shot mode, once it reaches zero it stays at zero.
- R5: In periodic mode (bit 17 of 0x320 set), the count reloads from the initial count on the tick that follows reaching zero. This gives one expiry every initial-count-plus-one ticks.
- R6: On expiry with the mask clear, irq_req rises with irq_vector equal to bits 7:0 of 0x320, and bit 12 of 0x320 reads as one. Both stay set until irq_ack, and both clear on the cycle after irq_ack.
- R7: While bit 16 of 0x320 is set, an expiry raises no request and does not set bit 12.
- R8: An expiry in the same cycle as irq_ack leaves the request asserted.
- R9: Reads of unmapped offsets return zero. Writes to 0x390 and writes to bit 12 of 0x320 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 12 | Register byte offset |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| irq_req | output | 1 | Pending interrupt request |
| irq_vector | output | 8 | Vector carried with the request |
| irq_ack | input | 1 | Acceptance of the request by the interrupt core |

## Verification
A periodic expiry and the acknowledge of an earlier request can land on the same clock edge. The bench leaves one periodic request unacknowledged. It then holds irq_ack across exactly the edge on which the next expiry is due, which is found by counting prescaler ticks from the initial-count write. It expects irq_req to remain high with the same vector. A second, lone acknowledge must then clear the request.

// File: rtl/lapic_timer.sv
module lapic_timer #(
  parameter int AW = 12,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] reg_addr,
  input  logic          reg_we,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          irq_req,
  output logic [7:0]    irq_vector,
  input  logic          irq_ack
);
  localparam logic [AW-1:0] A_CTL  = AW'('h320);
  localparam logic [AW-1:0] A_INIT = AW'('h380);
  localparam logic [AW-1:0] A_CUR  = AW'('h390);
  localparam logic [AW-1:0] A_DIV  = AW'('h3E0);

  logic [7:0]    vec;
  logic          msk, per, pend, run;
  logic [3:0]    div;
  logic [CW-1:0] init_q, cur;
  logic [6:0]    pre, lim;
  logic [2:0]    sh;
  logic          tick, expire;

  wire wr_ctl  = reg_we && reg_addr == A_CTL;
  wire wr_init = reg_we && reg_addr == A_INIT;
  wire wr_div  = reg_we && reg_addr == A_DIV;

  always_comb begin
    if (div[3] && div[1:0] == 2'b11) sh = 3'd0;
    else sh = {1'b0, div[1:0]} + (div[3] ? 3'd5 : 3'd1);
    lim = 7'((8'd1 << sh) - 8'd1);
  end

  assign tick   = pre == lim;
  assign expire = tick && run && cur == CW'(1) && !wr_init;

  always_ff @(posedge clk) begin
    if (!rst_n) pre <= '0;
    else if (wr_init || wr_div || tick) pre <= '0;
    else pre <= pre + 7'd1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vec <= '0; msk <= 1'b1; per <= 1'b0; div <= '0; init_q <= '0;
    end else begin
      if (wr_ctl) begin
        vec <= reg_wdata[7:0];
        msk <= reg_wdata[16];
        per <= reg_wdata[17];
      end
      if (wr_div)  div <= reg_wdata[3:0];
      if (wr_init) init_q <= reg_wdata[CW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= '0; run <= 1'b0;
    end else if (wr_init) begin
      cur <= reg_wdata[CW-1:0];
      run <= reg_wdata[CW-1:0] != '0;
    end else if (tick && run) begin
      if (cur == CW'(1)) begin
        cur <= '0;
        if (!per) run <= 1'b0;
      end else if (cur == '0) cur <= init_q;
      else cur <= cur - CW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) pend <= 1'b0;
    else if (expire && !msk) pend <= 1'b1;
    else if (irq_ack) pend <= 1'b0;
  end

  assign irq_req    = pend;
  assign irq_vector = vec;

  always_comb begin
    case (reg_addr)
      A_CTL:   reg_rdata = {14'd0, per, msk, 3'd0, pend, 4'd0, vec};
      A_INIT:  reg_rdata = 32'(init_q);
      A_CUR:   reg_rdata = 32'(cur);
      A_DIV:   reg_rdata = {28'd0, div};
      default: reg_rdata = '0;
    endcase
  end

  AST_REQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && !irq_ack |=> irq_req); // R6
  AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && irq_ack && !expire |=> !irq_req); // R6
  AST_MASK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req && msk |=> !irq_req); // R7
  AST_EXPIRY_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    expire && !msk |=> irq_req); // R8
  AST_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    !run && !wr_init |=> $stable(cur)); // R4
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    tick && run && cur > CW'(1) && !wr_init |=> cur == $past(cur) - CW'(1)); // R4
endmodule

// File: tb/sim_lapic_timer.sv
`timescale 1ns/1ps
module sim_lapic_timer;
  logic clk = 0, rst_n = 0, reg_we = 0, irq_ack = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic irq_req;
  logic [7:0] irq_vector;
  always #4 clk = ~clk;

  lapic_timer u0 (.clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_req(irq_req),
    .irq_vector(irq_vector), .irq_ack(irq_ack));

  typedef struct { int kind; logic [31:0] exp; string tag; } item_t;
  item_t q[$];
  int total = 0, bad = 0;
  logic smp = 0, done = 0;

  always @(negedge clk) if (smp && q.size() > 0) begin
    item_t it;
    logic [31:0] act;
    it = q.pop_front();
    act = it.kind == 0 ? reg_rdata : it.kind == 1 ? {23'd0, irq_req, irq_vector} : {31'd0, irq_req};
    total++;
    if (act !== it.exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", it.tag, act, it.exp);
    end
  end

  task automatic step(); @(posedge clk); #1; endtask
  task automatic idle(int n); repeat (n) step(); endtask
  task automatic wr(logic [11:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_we = 1; step(); reg_we = 0;
  endtask
  task automatic rd(logic [11:0] a, logic [31:0] e, string tag);
    item_t it;
    it.kind = 0; it.exp = e; it.tag = tag; q.push_back(it);
    reg_addr = a; smp = 1; step(); smp = 0;
  endtask
  task automatic chk_irq(logic req, logic [7:0] v, string tag);
    item_t it;
    it.kind = req ? 1 : 2; it.exp = req ? {23'd0, 1'b1, v} : 32'd0; it.tag = tag;
    q.push_back(it);
    smp = 1; step(); smp = 0;
  endtask
  task automatic ack(); irq_ack = 1; step(); irq_ack = 0; endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle(3); rst_n = 1; step();
    rd(12'h320, 32'h0001_0000, "R1 ctl");
    rd(12'h380, 0, "R1 init");
    rd(12'h390, 0, "R1 cur");
    rd(12'h3E0, 0, "R1 div");
    chk_irq(0, 0, "R1 irq");

    // One-shot at /1
    wr(12'h320, 32'h0000_0042);
    wr(12'h3E0, 32'hB);
    wr(12'h380, 5);
    rd(12'h390, 5, "R3 load");
    for (int i = 4; i >= 1; i--) rd(12'h390, i, "R4 step");
    rd(12'h320, 32'h0000_1042, "R6 status bit");
    chk_irq(1, 8'h42, "R6 request");
    idle(3);
    rd(12'h390, 0, "R4 one-shot rest");
    chk_irq(1, 8'h42, "R6 held");
    ack();
    chk_irq(0, 0, "R6 ack clears");
    rd(12'h320, 32'h0000_0042, "R6 status clear");

    // Periodic at /2, init 2
    wr(12'h320, 32'h0002_0055);
    wr(12'h3E0, 32'h0);
    wr(12'h380, 2);
    begin
      int exp_seq[9] = '{2, 2, 1, 1, 0, 0, 2, 2, 1};
      for (int i = 0; i < 9; i++) rd(12'h390, exp_seq[i], "R5 periodic");
    end
    ack();  // covers the second expiry edge
    chk_irq(1, 8'h55, "R8 expiry with ack");
    ack();
    chk_irq(0, 0, "R6 lone ack clears");

    // Masked expiry
    wr(12'h320, 32'h0001_0077);
    wr(12'h3E0, 32'hB);
    wr(12'h380, 3);
    idle(5);
    chk_irq(0, 0, "R7 masked");
    rd(12'h320, 32'h0001_0077, "R7 no status");
    rd(12'h390, 0, "R7 count still ran");

    // Divide codes
    begin
      logic [3:0] codes[9] = '{4'h0, 4'h1, 4'h2, 4'h3, 4'h8, 4'h9, 4'hA, 4'hB, 4'h4};
      int ratio[9] = '{2, 4, 8, 16, 32, 64, 128, 1, 2};
      for (int k = 0; k < 9; k++) begin
        wr(12'h3E0, {28'd0, codes[k]});
        wr(12'h380, 2);
        idle(ratio[k] - 1);
        rd(12'h390, 2, "R2 before tick");
        rd(12'h390, 1, "R2 first tick");
        rd(12'h3E0, {28'd0, codes[k]}, "R2 readback");
      end
    end

    // Zero write stops
    wr(12'h3E0, 32'hB);
    wr(12'h380, 100);
    idle(2);
    wr(12'h380, 0);
    rd(12'h390, 0, "R3 zero stops");
    idle(3);
    rd(12'h390, 0, "R3 stays stopped");
    chk_irq(0, 0, "R3 no irq");

    // Read-only and unmapped
    wr(12'h390, 32'h1234);
    rd(12'h390, 0, "R9 cur write ignored");
    wr(12'h320, 32'h0001_1099);
    rd(12'h320, 32'h0001_0099, "R9 status write ignored");
    rd(12'h3F0, 0, "R9 unmapped");
    rd(12'h000, 0, "R9 unmapped low");

    idle(2);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule